// File: doc/BRIEF.md
# Circular Pass-Window Phase Selector

This block picks a sampling phase from a pass/fail map of one clock period. The period is divided into a power-of-two number of phases, 32 by default, and each phase has one bit in an input mask. A set bit means a trial at that phase succeeded. The block finds the longest unbroken stretch of passing phases and returns the phase at its centre. The mask is treated as a ring, so a stretch can run off the top phase and continue at phase 0.

A search starts with a one-cycle `start` pulse, and the mask is captured on that edge. The block then measures one whole run of passing phases per cycle. After each run it jumps over the following gap of failing phases. The search finishes with a one-cycle `valid` pulse and the chosen phase, or with a one-cycle `error` pulse when no phase passed. Two masks are answered on the edge that accepts them, with no search: a mask with no set bits, and a mask with every bit set (which gives phase 0). The phase output keeps its value until the next result.

Top module: `phase_window_picker`

## Requirements
- R1: Bit k of `mask_in` set to 1 means phase k passed. The result on `phase` is the start of the chosen run plus half its length, rounded down.
- R2: A mask with no set bit gives a one-cycle `error` on the cycle after the accepting edge. No `valid` pulse is produced for that search.
- R3: A mask with every bit set gives `valid` with `phase` = 0 on the cycle after the accepting edge.
- R4: Runs are measured on the ring. A run covering phase PHASES-1 continues into phase 0 and upward, and counts as one run.
- R5: Runs are visited starting at the lowest set bit and moving upward. A later run replaces the best run only when it is strictly longer, so the earliest visited run wins a tie.
- R6: `valid` and `error` are each high for exactly one cycle per result and are never high together. `phase` holds its value while `valid` is low.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It does not change the result or the mask being searched.
- R8: `valid` or `error` rises no more than 33 cycles after the edge that accepted `start`.
- R9: `busy` is low after reset. It is high from the cycle after a mask is accepted for searching until the cycle that carries `valid`, and `valid` never rises while `busy` is still high.
- R10: The centre phase is reduced modulo PHASES. A wrapping run whose start plus half its length reaches PHASES or more yields a small phase number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search with `mask_in`; ignored while busy |
| mask_in | input | PHASES | Pass map, one bit per phase |
| busy | output | 1 | Search in progress |
| phase | output | log2(PHASES) | Chosen sampling phase, held until the next result |
| valid | output | 1 | One-cycle pulse: `phase` carries a new result |
| error | output | 1 | One-cycle pulse: no phase passed |

## Verification
The bench builds the block with its default of 32 phases. This is the only width at which the 33-cycle bound and the ring positions that the directed masks use have meaning. At this width, a single-bit gap at phase 0 and runs that straddle phase 31 are within reach. So is a midpoint that lands past 31 and wraps. The alternating mask gives the largest number of runs, so it drives the search to its longest path. A table-free reference model in the bench also checks a spread of pseudo-random masks at that width.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
   typedef enum logic {
      PWP_IDLE = 1'b0,
      PWP_SCAN = 1'b1
   } pwp_state_t;
endpackage

// File: rtl/pwp_low_bit.sv
// Position of the lowest set bit; returns N when the vector is all zero.
module pwp_low_bit #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0]          vec,
   output logic [$clog2(N):0]    count
);
   localparam int unsigned CW = $clog2(N) + 1;

   always_comb begin
      count = CW'(N);
      for (int k = N - 1; k >= 0; k--) begin
         if (vec[k]) count = CW'(k);
      end
   end
endmodule

// File: rtl/pwp_ring_rotate.sv
// Rotate right: dout[k] = din[(k + amt) mod N], N a power of two.
module pwp_ring_rotate #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0]          din,
   input  logic [$clog2(N)-1:0]  amt,
   output logic [N-1:0]          dout
);
   localparam int unsigned IW = $clog2(N);

   for (genvar k = 0; k < N; k++) begin : g_tap
      localparam logic [IW-1:0] KPOS = IW'(k);
      logic [IW-1:0] src;
      assign src     = KPOS + amt;
      assign dout[k] = din[src];
   end
endmodule

// File: rtl/phase_window_picker.sv
module phase_window_picker #(
   parameter int unsigned PHASES = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [PHASES-1:0]          mask_in,
   output logic                       busy,
   output logic [$clog2(PHASES)-1:0]  phase,
   output logic                       valid,
   output logic                       error
);
   import pwp_pkg::*;

   localparam int unsigned IW = $clog2(PHASES);
   localparam int unsigned CW = IW + 1;
   localparam int unsigned SW = IW + 2;

   if (PHASES < 4 || (PHASES & (PHASES - 1)) != 0) begin : g_bad_phases
      $error("PHASES must be a power of two of at least 4");
   end

   pwp_state_t       state_q;
   logic [PHASES-1:0] mask_q;
   logic [IW-1:0]    idx_q;
   logic [IW-1:0]    best_start_q;
   logic [CW-1:0]    best_len_q;
   logic [IW-1:0]    phase_q;
   logic             valid_q;
   logic             error_q;

   // lowest passing phase of the incoming mask
   logic [CW-1:0]    first_idx;
   logic             in_none;
   logic             in_all;

   pwp_low_bit #(.N(PHASES)) u_first (
      .vec   (mask_in),
      .count (first_idx)
   );

   assign in_none = (first_idx == CW'(PHASES));
   assign in_all  = &mask_in;

   // one run per cycle: rotate so the current run sits at bit 0
   logic [PHASES-1:0] rot_v;
   logic [CW-1:0]    run_len;
   logic [PHASES-1:0] after_run;
   logic [CW-1:0]    gap_len;

   pwp_ring_rotate #(.N(PHASES)) u_rot (
      .din  (mask_q),
      .amt  (idx_q),
      .dout (rot_v)
   );

   pwp_low_bit #(.N(PHASES)) u_run (
      .vec   (~rot_v),
      .count (run_len)
   );

   assign after_run = rot_v >> run_len;

   pwp_low_bit #(.N(PHASES)) u_gap (
      .vec   (after_run),
      .count (gap_len)
   );

   logic [SW-1:0] next_idx;
   logic          no_more;
   logic          longer;
   logic [IW-1:0] sel_start;
   logic [CW-1:0] sel_len;
   logic [IW-1:0] centre;

   assign next_idx  = SW'(idx_q) + SW'(run_len) + SW'(gap_len);
   assign no_more   = (gap_len == CW'(PHASES)) || (next_idx >= SW'(PHASES));
   assign longer    = run_len > best_len_q;
   assign sel_start = longer ? idx_q   : best_start_q;
   assign sel_len   = longer ? run_len : best_len_q;
   assign centre    = sel_start + IW'(sel_len >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= PWP_IDLE;
         mask_q       <= '0;
         idx_q        <= '0;
         best_start_q <= '0;
         best_len_q   <= '0;
         phase_q      <= '0;
         valid_q      <= 1'b0;
         error_q      <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         error_q <= 1'b0;
         unique case (state_q)
            PWP_IDLE: begin
               if (start) begin
                  if (in_none) begin
                     error_q <= 1'b1;
                  end else if (in_all) begin
                     valid_q <= 1'b1;
                     phase_q <= '0;
                  end else begin
                     mask_q       <= mask_in;
                     idx_q        <= first_idx[IW-1:0];
                     best_start_q <= '0;
                     best_len_q   <= '0;
                     state_q      <= PWP_SCAN;
                  end
               end
            end
            PWP_SCAN: begin
               best_start_q <= sel_start;
               best_len_q   <= sel_len;
               if (no_more) begin
                  phase_q <= centre;
                  valid_q <= 1'b1;
                  state_q <= PWP_IDLE;
               end else begin
                  idx_q <= next_idx[IW-1:0];
               end
            end
            default: state_q <= PWP_IDLE;
         endcase
      end
   end

   assign busy  = (state_q == PWP_SCAN);
   assign phase = phase_q;
   assign valid = valid_q;
   assign error = error_q;
endmodule

// File: rtl/phase_window_picker_chk.sv
module phase_window_picker_chk #(
   parameter int unsigned PHASES = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic [PHASES-1:0]          mask_in,
   input logic                       busy,
   input logic [$clog2(PHASES)-1:0]  phase,
   input logic                       valid,
   input logic                       error
);
   localparam int unsigned LIM = PHASES + 1;

   int unsigned busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && error)); // R6
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R6
   AST_ERROR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error); // R6
   AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(phase)); // R6
   AST_EMPTY_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mask_in == '0) |=> (error && !valid)); // R2
   AST_FULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (&mask_in)) |=> (valid && phase == '0)); // R3
   AST_BUSY_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mask_in != '0 && !(&mask_in)) |=> busy); // R9
   AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !busy); // R9
   AST_BOUNDED_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= LIM); // R8
endmodule

bind phase_window_picker phase_window_picker_chk #(.PHASES(PHASES)) u_chk (.*);

// File: tb/phase_window_picker_test.sv
module phase_window_picker_test;
   localparam int unsigned PHASES = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] mask_in = '0;
   logic        busy;
   logic [4:0]  phase;
   logic        valid;
   logic        error;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   phase_window_picker #(.PHASES(PHASES)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mask_in(mask_in),
      .busy(busy), .phase(phase), .valid(valid), .error(error)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // model of the requirements: ring scan from lowest set bit, strict replace
   function automatic int model_phase(input logic [31:0] m);
      int bs, bl, i, len, k;
      logic [31:0] v;
      bs = 0; bl = 0;
      if (&m) return 0;
      i = 0;
      while (!m[i]) i++;
      while (i < 32) begin
         v = (m >> i) | (m << (32 - i));
         if (i == 0) v = m;
         len = 0;
         while (len < 32 && v[len]) len++;
         if (len > bl) begin bl = len; bs = i; end
         k = len;
         while (k < 32 && !v[k]) k++;
         if (k >= 32) break;
         i = i + k;
      end
      return (bs + bl / 2) % 32;
   endfunction

   task automatic launch(input logic [31:0] m, output int ph, output bit v,
                         output bit e, output int cyc);
      @(negedge clk);
      start = 1'b1; mask_in = m;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!valid && !error && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      ph = phase; v = valid; e = error;
   endtask

   task automatic run_expect(input logic [31:0] m, input int exp, input string req);
      int ph, cyc; bit v, e;
      launch(m, ph, v, e, cyc);
      check(v && !e, {req, " valid"}, v, 1);
      check(ph == exp, {req, " phase"}, ph, exp);
      check(cyc <= 33, "R8 latency", cyc, 33);
      @(negedge clk);
      check(!valid && phase == exp, "R6 pulse/hold", valid, 0);
   endtask

   task automatic t_reset;
      check(!busy && !valid && !error, "R9 reset idle", busy, 0);
   endtask

   task automatic t_empty;
      int ph, cyc; bit v, e;
      launch(32'h0, ph, v, e, cyc);
      check(e && !v && cyc == 1, "R2 empty error", cyc, 1);
      @(negedge clk);
      check(!error && !valid, "R6 error pulse", error, 0);
   endtask

   task automatic t_full;
      int ph, cyc; bit v, e;
      launch(32'hFFFF_FFFF, ph, v, e, cyc);
      check(v && ph == 0 && cyc == 1, "R3 all pass", ph, 0);
   endtask

   task automatic t_basic;
      run_expect(32'h0000_0020, 5,  "R1 single");
      run_expect(32'h0000_0FF0, 8,  "R1 block");
      run_expect(32'hFFFF_FFFE, 16, "R1 gap at zero");
      run_expect(32'h01F0_0002, 22, "R5 longer later");
   endtask

   task automatic t_ring;
      run_expect(32'hF000_0003, 31, "R4 wrap run");
      run_expect(32'hC000_040F, 1,  "R10 centre wraps");
   endtask

   task automatic t_tie;
      run_expect(32'h0000_1C1C, 3, "R5 tie first");
      run_expect(32'h5555_5555, 0, "R5 many ties");
   endtask

   task automatic t_busy_start;
      int cyc;
      @(negedge clk);
      start = 1'b1; mask_in = 32'h5555_5555;
      @(negedge clk);
      check(busy, "R9 busy during search", busy, 1);
      mask_in = 32'h0000_0020;          // start held high while busy
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!valid && !error && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      check(valid && phase == 0, "R7 start ignored", phase, 0);
      @(negedge clk);
      check(!busy && !valid, "R7 no second result", valid, 0);
   endtask

   task automatic t_sweep;
      logic [31:0] lfsr = 32'hACE1_2468;
      logic [31:0] m;
      for (int n = 0; n < 40; n++) begin
         for (int s = 0; s < 7; s++)
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         m = (n % 3 == 0) ? (lfsr & {lfsr[15:0], lfsr[31:16]}) :
             (n % 3 == 1) ? (lfsr | {lfsr[7:0], lfsr[31:8]}) : lfsr;
         if (m == 0 || &m) m = 32'h0F0F_00F1;
         run_expect(m, model_phase(m), "R1 sweep");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_empty();
      t_full();
      t_basic();
      t_ring();
      t_tie();
      t_busy_start();
      t_sweep();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule